// File: doc/BRIEF.md
# Remote DMA Engine with Receive-Ring Wrap

This block moves data between a host data port and a small byte-addressed local memory that the engine holds itself. The host first loads a 16-bit current address and a 16-bit byte count, one byte at a time, through a register strobe interface. It also sets the receive-ring bounds as 8-bit page numbers, where a page is 256 bytes. Each strobe on the data port then reads or writes 1, 2 or 4 bytes at the current address. After the access the address advances by the access size, and the count drops by the same amount.

If the address lands exactly on the ring end page, it jumps back to the ring start page. When the count runs out, the engine raises a completion flag in an interrupt status byte, and a mask byte decides whether that flag drives the interrupt line. A command with a zero count completes at once. The local memory has two parts: a small low region at address 0 and a packet window further up. Writes outside these two parts are dropped, and reads outside them return all ones.

Top module: `rdma_ring`

## Requirements
- R1: After reset the status byte reads 0x80, address and count read 0, and `irq` is low.
- R2: Register selects 3 and 4 load the address low and high byte, and 5 and 6 load the count low and high byte. Writing one half leaves the other half unchanged. A register write to address or count in the same cycle as a data access overrides the access's update.
- R3: The access size is 4 when `dp_wide` is high, otherwise 2 when bit 0 of the config byte (select 7) is set, otherwise 1. After each access the address grows by the size.
- R4: Two- and four-byte accesses use the address with bit 0 cleared. Bytes are stored and returned little-endian, lowest address in `dp_wdata`/`dp_rdata` bits 7:0. The stored address itself still advances from its unaligned value.
- R5: If the advanced address equals stop page × 256 (stop page at select 2), it is replaced by start page × 256 (select 1).
- R6: If the count is at most the access size, the count becomes 0 and status bit 6 is set. Otherwise the count is reduced by the size.
- R7: A data-port write while the count is 0 changes neither memory, address, count nor status. A data-port read at count 0 still proceeds: it returns data, advances the address, keeps the count at 0 and sets bit 6.
- R8: A command write (select 0) with bit 0 clear clears status bit 7. If that command also has bit 3 or bit 4 set while the count is 0, it sets status bit 6. A command with bit 0 set does neither.
- R9: Memory bytes exist below LOW_BYTES and in [PKT_BASE, PKT_BASE+PKT_BYTES). Each byte of an access outside these is not written, and reads as 0xFF.
- R10: `irq` is high exactly when status AND mask (select 8) has any of bits 6:0 set. Status bit 7 never raises it.
- R11: Writing select 9 clears each status bit written as 1. If a set and a clear of the same bit fall in one cycle, the set wins.
- R12: Read data appears on `dp_rdata` after the clock edge that samples `dp_rd`, and holds until the next read. Bytes beyond the access size read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 4 | Register select |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_sel` (combinational) |
| dp_wr | input | 1 | Data-port write strobe |
| dp_rd | input | 1 | Data-port read strobe (takes precedence over `dp_wr`) |
| dp_wide | input | 1 | Selects the 4-byte access path |
| dp_wdata | input | 32 | Data-port write data |
| dp_rdata | output | 32 | Data-port read data, registered |
| irq | output | 1 | Interrupt request |

## Verification
The completion flag can be set by the last data-port access in the same cycle that the host writes a 1 to clear it. The bench provokes this by raising `dp_rd` with a count of 1 and, on the same clock edge, writing 0x40 to the status register. It then reads the status byte and expects bit 6 still set and the count at 0. A plain clear afterwards must drop the bit and the interrupt line.

// File: rtl/rdma_ring.sv
module rdma_ring #(
  parameter int LOW_BYTES = 32,
  parameter int PKT_BASE  = 16'h4000,
  parameter int PKT_BYTES = 512
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [3:0]  reg_sel,
  input  logic [7:0]  reg_wdata,
  output logic [7:0]  reg_rdata,
  input  logic        dp_wr,
  input  logic        dp_rd,
  input  logic        dp_wide,
  input  logic [31:0] dp_wdata,
  output logic [31:0] dp_rdata,
  output logic        irq
);
  localparam int DEPTH = LOW_BYTES + PKT_BYTES;
  localparam int IW = $clog2(DEPTH);
  localparam logic [16:0] LOW_END = 17'(LOW_BYTES);
  localparam logic [16:0] PKT_LO  = 17'(PKT_BASE);
  localparam logic [16:0] PKT_HI  = 17'(PKT_BASE + PKT_BYTES);

  localparam logic [3:0] SEL_CMD = 4'd0, SEL_PSTART = 4'd1, SEL_PSTOP = 4'd2,
                         SEL_ALO = 4'd3, SEL_AHI = 4'd4, SEL_CLO = 4'd5,
                         SEL_CHI = 4'd6, SEL_CFG = 4'd7, SEL_MASK = 4'd8,
                         SEL_ISR = 4'd9;

  logic [7:0]  pstart_q, pstop_q, cfg_q, mask_q, isr_q;
  logic [15:0] addr_q, cnt_q;
  logic [7:0]  mem [DEPTH];

  logic [2:0]  step;
  logic [15:0] base, adv, addr_nx, cnt_nx;
  logic        acc_wr, acc, done, cmd_go, cmd_rdc;
  logic [IW-1:0] idx [4];
  logic        hit [4];
  logic [7:0]  rbyte [4];
  logic [7:0]  isr_set, isr_clr;

  assign step    = dp_wide ? 3'd4 : (cfg_q[0] ? 3'd2 : 3'd1);
  assign base    = (dp_wide || cfg_q[0]) ? {addr_q[15:1], 1'b0} : addr_q;
  assign acc_wr  = dp_wr && !dp_rd && (cnt_q != 16'd0);
  assign acc     = dp_rd || acc_wr;
  assign adv     = addr_q + 16'(step);
  assign addr_nx = (adv == {pstop_q, 8'h00}) ? {pstart_q, 8'h00} : adv;
  assign done    = acc && (cnt_q <= 16'(step));
  assign cnt_nx  = done ? 16'd0 : cnt_q - 16'(step);

  assign cmd_go  = reg_wr && (reg_sel == SEL_CMD) && !reg_wdata[0];
  assign cmd_rdc = cmd_go && (reg_wdata[3] || reg_wdata[4]) && (cnt_q == 16'd0);
  assign isr_set = {1'b0, done || cmd_rdc, 6'd0};
  assign isr_clr = ((reg_wr && reg_sel == SEL_ISR) ? reg_wdata : 8'h00) |
                   {cmd_go, 7'd0};

  assign irq = |(isr_q & mask_q & 8'h7f);

  always_comb begin
    for (int k = 0; k < 4; k++) begin
      logic [16:0] a17, off;
      a17 = {1'b0, base + 16'(k)};
      hit[k] = (a17 < LOW_END) || (a17 >= PKT_LO && a17 < PKT_HI);
      off = (a17 < LOW_END) ? a17 : (a17 - PKT_LO + LOW_END);
      idx[k] = off[IW-1:0];
      rbyte[k] = hit[k] ? mem[idx[k]] : 8'hff;
    end
  end

  always_ff @(posedge clk) begin
    for (int k = 0; k < 4; k++)
      if (acc_wr && 3'(k) < step && hit[k]) mem[idx[k]] <= dp_wdata[8*k +: 8];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pstart_q <= 8'h00;
      pstop_q  <= 8'h00;
      cfg_q    <= 8'h00;
      mask_q   <= 8'h00;
      isr_q    <= 8'h80;
      addr_q   <= 16'h0000;
      cnt_q    <= 16'h0000;
      dp_rdata <= 32'h0;
    end else begin
      isr_q <= (isr_q & ~isr_clr) | isr_set;
      if (acc) begin
        addr_q <= addr_nx;
        cnt_q  <= cnt_nx;
      end
      if (dp_rd)
        dp_rdata <= {step[2] ? {rbyte[3], rbyte[2]} : 16'h0,
                     (step != 3'd1) ? rbyte[1] : 8'h0, rbyte[0]};
      if (reg_wr) begin
        case (reg_sel)
          SEL_PSTART: pstart_q <= reg_wdata;
          SEL_PSTOP:  pstop_q  <= reg_wdata;
          SEL_ALO:    addr_q   <= {addr_q[15:8], reg_wdata};
          SEL_AHI:    addr_q   <= {reg_wdata, addr_q[7:0]};
          SEL_CLO:    cnt_q    <= {cnt_q[15:8], reg_wdata};
          SEL_CHI:    cnt_q    <= {reg_wdata, cnt_q[7:0]};
          SEL_CFG:    cfg_q    <= reg_wdata;
          SEL_MASK:   mask_q   <= reg_wdata;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (reg_sel)
      SEL_PSTART: reg_rdata = pstart_q;
      SEL_PSTOP:  reg_rdata = pstop_q;
      SEL_ALO:    reg_rdata = addr_q[7:0];
      SEL_AHI:    reg_rdata = addr_q[15:8];
      SEL_CLO:    reg_rdata = cnt_q[7:0];
      SEL_CHI:    reg_rdata = cnt_q[15:8];
      SEL_CFG:    reg_rdata = cfg_q;
      SEL_MASK:   reg_rdata = mask_q;
      SEL_ISR:    reg_rdata = isr_q;
      default:    reg_rdata = 8'h00;
    endcase
  end
endmodule

// File: rtl/rdma_ring_chk.sv
module rdma_ring_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_wr,
  input logic        dp_wr,
  input logic        dp_rd,
  input logic        dp_wide,
  input logic        irq,
  input logic [15:0] addr,
  input logic [15:0] cnt,
  input logic [7:0]  isr,
  input logic [7:0]  mask,
  input logic [7:0]  cfg,
  input logic [7:0]  pstart,
  input logic [7:0]  pstop
);
  assert_wr_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (dp_wr && !dp_rd && !reg_wr && cnt == 16'd0) |=> (cnt == 16'd0 && addr == $past(addr)));

  assert_cnt_no_grow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_wr |=> (cnt <= $past(cnt)));

  assert_last_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (dp_rd && !reg_wr && cnt == 16'd1) |=> (cnt == 16'd0 && isr[6]));

  assert_ring_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (dp_rd && !reg_wr && !dp_wide && !cfg[0] && (addr + 16'd1) == {pstop, 8'h00})
      |=> (addr == {pstart, 8'h00}));

  assert_mask_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mask[6:0] == 7'd0) |-> !irq);

  assert_flag_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (isr[6] && !reg_wr) |=> isr[6]);
endmodule

bind rdma_ring rdma_ring_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .dp_wr(dp_wr), .dp_rd(dp_rd),
  .dp_wide(dp_wide), .irq(irq), .addr(addr_q), .cnt(cnt_q), .isr(isr_q),
  .mask(mask_q), .cfg(cfg_q), .pstart(pstart_q), .pstop(pstop_q)
);

// File: tb/sim_rdma_ring.sv
module sim_rdma_ring;
  logic        clk = 0, rst_n = 0;
  logic        reg_wr = 0, dp_wr = 0, dp_rd = 0, dp_wide = 0;
  logic [3:0]  reg_sel = 0;
  logic [7:0]  reg_wdata = 0, reg_rdata;
  logic [31:0] dp_wdata = 0, dp_rdata;
  logic        irq;
  int errors = 0, checks = 0;

  always #5 clk = ~clk;

  rdma_ring u0 (.clk, .rst_n, .reg_wr, .reg_sel, .reg_wdata, .reg_rdata,
                .dp_wr, .dp_rd, .dp_wide, .dp_wdata, .dp_rdata, .irq);

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wreg(input logic [3:0] s, input logic [7:0] d);
    @(negedge clk); reg_wr = 1; reg_sel = s; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rreg(input logic [3:0] s, output logic [7:0] d);
    reg_sel = s; #1; d = reg_rdata;
  endtask

  task automatic dpw(input logic [31:0] d, input bit wide);
    @(negedge clk); dp_wr = 1; dp_wdata = d; dp_wide = wide;
    @(negedge clk); dp_wr = 0; dp_wide = 0;
  endtask

  task automatic dpr(input bit wide, output logic [31:0] d);
    @(negedge clk); dp_rd = 1; dp_wide = wide;
    @(negedge clk); dp_rd = 0; dp_wide = 0; d = dp_rdata;
  endtask

  task automatic set_ac(input logic [15:0] a, input logic [15:0] c);
    wreg(4'd3, a[7:0]); wreg(4'd4, a[15:8]);
    wreg(4'd5, c[7:0]); wreg(4'd6, c[15:8]);
  endtask

  task automatic get16(input logic [3:0] lo, output logic [15:0] v);
    logic [7:0] l, h;
    rreg(lo, l); rreg(lo + 4'd1, h); v = {h, l};
  endtask

  task automatic t_reset;
    logic [7:0] v; logic [15:0] w;
    rreg(4'd9, v); chk(v == 8'h80, "R1 isr", v, 8'h80);
    get16(4'd3, w); chk(w == 0, "R1 addr", w, 0);
    get16(4'd5, w); chk(w == 0, "R1 cnt", w, 0);
    chk(irq == 0, "R1 irq", irq, 0);
    wreg(4'd8, 8'h80);
    chk(irq == 0, "R10 bit7 masked out", irq, 0);
    wreg(4'd0, 8'h22);
    rreg(4'd9, v); chk(v == 8'h00, "R8 start clears bit7", v, 0);
  endtask

  task automatic t_load;
    logic [15:0] w;
    wreg(4'd3, 8'h34); wreg(4'd4, 8'h12);
    get16(4'd3, w); chk(w == 16'h1234, "R2 addr", w, 16'h1234);
    wreg(4'd4, 8'h56);
    get16(4'd3, w); chk(w == 16'h5634, "R2 hi keeps lo", w, 16'h5634);
    wreg(4'd5, 8'hAA); wreg(4'd6, 8'h01);
    get16(4'd5, w); chk(w == 16'h01AA, "R2 cnt", w, 16'h01AA);
  endtask

  task automatic t_bytes;
    logic [15:0] w; logic [7:0] v; logic [31:0] d;
    wreg(4'd7, 8'h00); wreg(4'd1, 8'h40); wreg(4'd2, 8'h42);
    set_ac(16'h4000, 16'd3);
    dpw(32'h11, 0);
    get16(4'd3, w); chk(w == 16'h4001, "R3 byte advance", w, 16'h4001);
    get16(4'd5, w); chk(w == 16'd2, "R3 byte count", w, 2);
    dpw(32'h22, 0); dpw(32'h33, 0);
    get16(4'd5, w); chk(w == 0, "R6 count done", w, 0);
    rreg(4'd9, v); chk(v[6], "R6 flag", v, 8'h40);
    wreg(4'd9, 8'hFF);
    set_ac(16'h4000, 16'd3);
    dpr(0, d); chk(d == 32'h11, "R12 read b0", d, 32'h11);
    dpr(0, d); chk(d == 32'h22, "R12 read b1", d, 32'h22);
    dpr(0, d); chk(d == 32'h33, "R12 read b2", d, 32'h33);
  endtask

  task automatic t_word;
    logic [15:0] w; logic [31:0] d;
    wreg(4'd7, 8'h01);
    set_ac(16'h4011, 16'd2);
    dpw(32'hCAFEBEEF, 0);
    get16(4'd3, w); chk(w == 16'h4013, "R4 unaligned advance", w, 16'h4013);
    wreg(4'd7, 8'h00);
    set_ac(16'h4010, 16'd2);
    dpr(0, d); chk(d == 32'hEF, "R4 low byte", d, 32'hEF);
    dpr(0, d); chk(d == 32'hBE, "R4 high byte", d, 32'hBE);
    wreg(4'd7, 8'h01);
    set_ac(16'h4011, 16'd2);
    dpr(0, d); chk(d == 32'hBEEF, "R4 word read", d, 32'hBEEF);
    wreg(4'd7, 8'h00);
  endtask

  task automatic t_dword;
    logic [15:0] w; logic [31:0] d;
    set_ac(16'h4020, 16'd8);
    dpw(32'h44332211, 1);
    get16(4'd3, w); chk(w == 16'h4024, "R3 dword advance", w, 16'h4024);
    get16(4'd5, w); chk(w == 16'd4, "R3 dword count", w, 4);
    set_ac(16'h4020, 16'd4);
    dpr(1, d); chk(d == 32'h44332211, "R4 dword LE", d, 32'h44332211);
  endtask

  task automatic t_wrap;
    logic [15:0] w; logic [31:0] d;
    wreg(4'd2, 8'h41);
    set_ac(16'h40FF, 16'd2);
    dpw(32'h5A, 0);
    get16(4'd3, w); chk(w == 16'h4000, "R5 wrap", w, 16'h4000);
    dpw(32'h6B, 0);
    set_ac(16'h40FF, 16'd2);
    dpr(0, d); chk(d == 32'h5A, "R5 before wrap", d, 32'h5A);
    dpr(0, d); chk(d == 32'h6B, "R5 after wrap", d, 32'h6B);
    wreg(4'd2, 8'h42);
  endtask

  task automatic t_zero;
    logic [15:0] w; logic [7:0] v; logic [31:0] d;
    wreg(4'd9, 8'hFF);
    set_ac(16'h4000, 16'd0);
    dpw(32'h99, 0);
    get16(4'd3, w); chk(w == 16'h4000, "R7 addr held", w, 16'h4000);
    rreg(4'd9, v); chk(v == 0, "R7 no flag", v, 0);
    dpr(0, d); chk(d == 32'h6B, "R7 mem untouched", d, 32'h6B);
    get16(4'd3, w); chk(w == 16'h4001, "R7 read advances", w, 16'h4001);
    get16(4'd5, w); chk(w == 0, "R7 read count stays", w, 0);
    rreg(4'd9, v); chk(v[6], "R7 read flags", v, 8'h40);
  endtask

  task automatic t_cmd;
    logic [7:0] v;
    wreg(4'd9, 8'hFF); set_ac(16'h4000, 16'd0);
    wreg(4'd0, 8'h09);
    rreg(4'd9, v); chk(v == 0, "R8 stopped no flag", v, 0);
    wreg(4'd0, 8'h0A);
    rreg(4'd9, v); chk(v == 8'h40, "R8 zero-length read", v, 8'h40);
    wreg(4'd9, 8'hFF);
    wreg(4'd0, 8'h12);
    rreg(4'd9, v); chk(v == 8'h40, "R8 zero-length write", v, 8'h40);
    wreg(4'd9, 8'hFF);
  endtask

  task automatic t_short;
    logic [15:0] w; logic [7:0] v;
    wreg(4'd7, 8'h01);
    set_ac(16'h4040, 16'd3);
    dpw(32'h1234, 0);
    get16(4'd5, w); chk(w == 1, "R6 partial count", w, 1);
    rreg(4'd9, v); chk(!v[6], "R6 not yet", v, 0);
    dpw(32'h5678, 0);
    get16(4'd5, w); chk(w == 0, "R6 short end", w, 0);
    rreg(4'd9, v); chk(v[6], "R6 short flag", v, 8'h40);
    wreg(4'd7, 8'h00); wreg(4'd9, 8'hFF);
  endtask

  task automatic t_map;
    logic [31:0] d;
    set_ac(16'h0005, 16'd1); dpw(32'h77, 0);
    set_ac(16'h0005, 16'd1); dpr(0, d);
    chk(d == 32'h77, "R9 low region", d, 32'h77);
    set_ac(16'h2000, 16'd1); dpw(32'h12, 0);
    set_ac(16'h2000, 16'd1); dpr(0, d);
    chk(d == 32'hFF, "R9 hole", d, 32'hFF);
    set_ac(16'h41FE, 16'd2); dpw(32'hA1, 0); dpw(32'hB2, 0);
    set_ac(16'h41FE, 16'd4); dpr(1, d);
    chk(d == 32'hFFFFB2A1, "R9 straddle", d, 32'hFFFFB2A1);
    wreg(4'd9, 8'hFF);
  endtask

  task automatic t_irq_same;
    logic [7:0] v; logic [15:0] w;
    wreg(4'd8, 8'h40);
    chk(irq == 0, "R10 idle", irq, 0);
    set_ac(16'h4000, 16'd1);
    @(negedge clk); dp_rd = 1; reg_wr = 1; reg_sel = 4'd9; reg_wdata = 8'h40;
    @(negedge clk); dp_rd = 0; reg_wr = 0;
    rreg(4'd9, v); chk(v[6], "R11 set wins", v, 8'h40);
    get16(4'd5, w); chk(w == 0, "R11 count", w, 0);
    chk(irq == 1, "R10 irq on", irq, 1);
    wreg(4'd8, 8'h00);
    chk(irq == 0, "R10 masked", irq, 0);
    wreg(4'd8, 8'h40);
    wreg(4'd9, 8'h40);
    rreg(4'd9, v); chk(v == 0, "R11 clear", v, 0);
    chk(irq == 0, "R10 irq off", irq, 0);
  endtask

  initial begin
    #1_000_000;
    errors++; checks++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset(); t_load(); t_bytes(); t_word(); t_dword(); t_wrap();
    t_zero(); t_cmd(); t_short(); t_map(); t_irq_same();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule